// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Translation Cache

This block caches recent virtual-to-physical page translations for a processor core. It is direct-mapped: the low bits of the virtual page number select one entry. Each entry keeps one physical page number and three separate tags, one for each kind of access: instruction fetch, data load and data store. A translation is therefore usable only for the access kinds that have been installed for it. When a fetch has installed a page, a load to that page still misses until the load kind is installed as well.

A combinational lookup port takes a virtual address and an access kind. In the same cycle it returns a hit flag and the physical address, which is the cached page number joined to the 12-bit page offset. An external page-table walker installs mappings through a refill port, one access kind at a time. A refill to an entry discards every other tag at that entry that names a different page. It always replaces the shared page number. A flush input empties the whole cache in one clock. Permission checks, table walking and memory access belong to the walker and the core, not to this block.

Top module: `split_tlb`

## Requirements
- R1: The entry index is the virtual page number modulo ENTRIES (its low log2(ENTRIES) bits). The stored tag is the whole virtual page number, so two pages with different indices can both hit at once.
- R2: A lookup hits only when the tag of the requested kind equals the virtual page number. Access kind encoding on both ports: 0 fetch, 1 load, 2 store, 3 treated as load.
- R3: On a hit, lk_paddr equals {stored physical page number, lk_vaddr[11:0]}. Lookup is combinational and uses the state as of the current cycle.
- R4: A refill writes only the tag of its own kind. A tag of another kind at that entry that already equals the new page number stays valid.
- R5: A refill invalidates every tag of another kind at its entry that differs from the new page number.
- R6: Every refill overwrites the entry's shared physical page number. A still-valid tag of another kind for the same page then translates to the new number.
- R7: A flush invalidates every tag of every entry at the next clock edge. A refill in the same cycle as a flush has no effect.
- R8: A synchronous active-low reset invalidates every tag, so every lookup misses after reset.
- R9: The invalid marker never matches a real page. A virtual page number of all ones misses after a flush and hits only after it is refilled.
- R10: A refill takes effect at the next clock edge. A lookup of the same page in the refill cycle still sees the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries at the next edge |
| lk_vaddr | input | VPN_W+12 | Lookup virtual address |
| lk_kind | input | 2 | Lookup access kind (0 fetch, 1 load, 2 store, 3 load) |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | PPN_W+12 | Lookup physical address, meaningful on hit |
| rf_valid | input | 1 | Refill request |
| rf_kind | input | 2 | Refill access kind |
| rf_vpn | input | VPN_W | Refill virtual page number |
| rf_ppn | input | PPN_W | Refill physical page number |

## Verification
On every cycle, the assertions check several things. A refill of a kind writes that kind's tag. It either keeps or invalidates each other tag, depending on whether that tag matches. The shared page number takes the refilled value. No lookup can hit in the cycle after a flush or a reset. Other properties come only from the bench's scenarios, which compare against a reference model on every clock. These are the kind separation seen from the lookup port, the offset join on the returned address, the alias-free all-ones page, and the same-cycle invisibility of a refill. The same holds for the way a shared page number replaced by one kind shows through another kind's still-valid tag.

// File: rtl/tlb_pkg.sv
// Shared definitions for the split-tag translation cache.
// Assumes access kinds arrive as 2-bit codes; code 3 is folded onto load.
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_ALT   = 2'd3
    } acc_t;

    localparam int NUM_KINDS = 3;
    localparam int PAGE_OFS_W = 12;

    // Map an access code onto the tag bank that serves it.
    function automatic int bank_of(input logic [1:0] code);
        case (acc_t'(code))
            ACC_FETCH: return 0;
            ACC_STORE: return 2;
            default:   return 1;
        endcase
    endfunction
endpackage

// File: rtl/tlb_tag_bank.sv
// One tag column (one access kind) of the translation cache.
// Tags are one bit wider than the page number; all-ones marks invalid,
// so no real page number (leading zero) can ever match it.
// Assumes rf_tag always carries a zero top bit.
module tlb_tag_bank #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 21,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             rf_en,
    input  logic             rf_own,
    input  logic [IDX_W-1:0] rf_idx,
    input  logic [TAG_W-1:0] rf_tag,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag
);
    localparam logic [TAG_W-1:0] INV = '1;

    logic [TAG_W-1:0] tag_q [ENTRIES];

    // Reset/flush clear all tags; refill writes or scrubs the indexed tag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int i = 0; i < ENTRIES; i++) tag_q[i] <= INV;
        end else if (rf_en) begin
            if (rf_own)
                tag_q[rf_idx] <= rf_tag;
            else if (tag_q[rf_idx] != rf_tag)
                tag_q[rf_idx] <= INV;
        end
    end

    // Read port for the lookup path.
    assign rd_tag = tag_q[rd_idx];

    a_r4_own_written: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en && rf_own && !flush) |=> tag_q[$past(rf_idx)] == $past(rf_tag));

    a_r4_match_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en && !rf_own && !flush && tag_q[rf_idx] == rf_tag)
        |=> tag_q[$past(rf_idx)] == $past(rf_tag));

    a_r5_mismatch_scrubbed: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en && !rf_own && !flush && tag_q[rf_idx] != rf_tag)
        |=> tag_q[$past(rf_idx)] == INV);
endmodule

// File: rtl/tlb_ppn_bank.sv
// Shared physical page number column; written by every refill.
// Assumes the caller gates writes with flush priority.
module tlb_ppn_bank #(
    parameter int ENTRIES = 16,
    parameter int PPN_W   = 22,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PPN_W-1:0] rd_ppn
);
    logic [PPN_W-1:0] ppn_q [ENTRIES];

    // Clear on reset, overwrite the indexed entry on each refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ppn_q[i] <= '0;
        end else if (wr_en) begin
            ppn_q[wr_idx] <= wr_ppn;
        end
    end

    // Read port for the lookup path.
    assign rd_ppn = ppn_q[rd_idx];

    a_r6_ppn_replaced: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ppn_q[$past(wr_idx)] == $past(wr_ppn));
endmodule

// File: rtl/tlb_lookup_sel.sv
// Combinational hit detection: picks the tag column for the access kind,
// compares it with the zero-extended page number and forms the address.
module tlb_lookup_sel #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 22,
    localparam int TAG_W = VPN_W + 1,
    localparam int OFS_W = tlb_pkg::PAGE_OFS_W
) (
    input  logic [TAG_W-1:0]       tag_fetch,
    input  logic [TAG_W-1:0]       tag_load,
    input  logic [TAG_W-1:0]       tag_store,
    input  logic [1:0]             kind,
    input  logic [VPN_W-1:0]       vpn,
    input  logic [OFS_W-1:0]       ofs,
    input  logic [PPN_W-1:0]       ppn,
    output logic                   hit,
    output logic [PPN_W+OFS_W-1:0] paddr
);
    logic [TAG_W-1:0] sel_tag;

    // Choose the tag column serving this access kind.
    always_comb begin
        case (tlb_pkg::bank_of(kind))
            0:       sel_tag = tag_fetch;
            2:       sel_tag = tag_store;
            default: sel_tag = tag_load;
        endcase
    end

    // Compare and join page number with offset.
    assign hit   = (sel_tag == {1'b0, vpn});
    assign paddr = {ppn, ofs};
endmodule

// File: rtl/split_tlb.sv
// Direct-mapped translation cache with per-kind tags over one shared
// physical page number. Lookup is combinational; refill and flush act
// on the next edge, flush winning over a same-cycle refill.
// Assumes ENTRIES is a power of two and at least 2.
module split_tlb #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 22,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int OFS_W  = tlb_pkg::PAGE_OFS_W,
    localparam int TAG_W  = VPN_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [VPN_W+OFS_W-1:0] lk_vaddr,
    input  logic [1:0]             lk_kind,
    output logic                   lk_hit,
    output logic [PPN_W+OFS_W-1:0] lk_paddr,
    input  logic                   rf_valid,
    input  logic [1:0]             rf_kind,
    input  logic [VPN_W-1:0]       rf_vpn,
    input  logic [PPN_W-1:0]       rf_ppn
);
    logic [VPN_W-1:0] lk_vpn;
    logic [IDX_W-1:0] lk_idx, rf_idx;
    logic             rf_go;
    logic [TAG_W-1:0] col_tag [tlb_pkg::NUM_KINDS];
    logic [PPN_W-1:0] ent_ppn;

    // Split the lookup address and derive both indices.
    assign lk_vpn = lk_vaddr[VPN_W+OFS_W-1:OFS_W];
    assign lk_idx = lk_vpn[IDX_W-1:0];
    assign rf_idx = rf_vpn[IDX_W-1:0];
    assign rf_go  = rf_valid && !flush;

    // One tag column per access kind.
    for (genvar b = 0; b < tlb_pkg::NUM_KINDS; b++) begin : g_col
        tlb_tag_bank #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_tags (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (flush),
            .rf_en  (rf_valid),
            .rf_own (tlb_pkg::bank_of(rf_kind) == b),
            .rf_idx (rf_idx),
            .rf_tag ({1'b0, rf_vpn}),
            .rd_idx (lk_idx),
            .rd_tag (col_tag[b])
        );
    end

    tlb_ppn_bank #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_ppn (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (rf_go),
        .wr_idx (rf_idx),
        .wr_ppn (rf_ppn),
        .rd_idx (lk_idx),
        .rd_ppn (ent_ppn)
    );

    tlb_lookup_sel #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_sel (
        .tag_fetch (col_tag[0]),
        .tag_load  (col_tag[1]),
        .tag_store (col_tag[2]),
        .kind      (lk_kind),
        .vpn       (lk_vpn),
        .ofs       (lk_vaddr[OFS_W-1:0]),
        .ppn       (ent_ppn),
        .hit       (lk_hit),
        .paddr     (lk_paddr)
    );

    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    a_r8_reset_empties: assert property (@(posedge clk)
        !rst_n |=> !lk_hit);
endmodule

// File: tb/split_tlb_test.sv
module split_tlb_test;
    localparam int ENT = 16;
    localparam int VW  = 20;
    localparam int PW  = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic [VW+11:0] lk_vaddr = '0;
    logic [1:0] lk_kind = '0;
    logic lk_hit;
    logic [PW+11:0] lk_paddr;
    logic rf_valid = 1'b0;
    logic [1:0] rf_kind = '0;
    logic [VW-1:0] rf_vpn = '0;
    logic [PW-1:0] rf_ppn = '0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Reference model: per kind, a page number or -1 when empty.
    int mtag [3][ENT];
    int mppn [ENT];

    split_tlb #(.ENTRIES(ENT), .VPN_W(VW), .PPN_W(PW)) uut (
        .clk, .rst_n, .flush, .lk_vaddr, .lk_kind, .lk_hit, .lk_paddr,
        .rf_valid, .rf_kind, .rf_vpn, .rf_ppn
    );

    always #4 clk = ~clk;

    function automatic int kmap(input logic [1:0] k);
        return (k == 2'd0) ? 0 : (k == 2'd2) ? 2 : 1;
    endfunction

    // Model update at each edge, from the requirement wording.
    always @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int k = 0; k < 3; k++)
                for (int e = 0; e < ENT; e++) mtag[k][e] = -1;
        end else if (rf_valid) begin
            int e;
            e = int'(rf_vpn) % ENT;
            for (int k = 0; k < 3; k++)
                if (mtag[k][e] != int'(rf_vpn)) mtag[k][e] = -1;
            mtag[kmap(rf_kind)][e] = int'(rf_vpn);
            mppn[e] = int'(rf_ppn);
        end
    end

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Compare outputs with the model, then advance one clock.
    task automatic step(input string rq);
        int vpn, e;
        bit eh;
        #1;
        vpn = int'(lk_vaddr[VW+11:12]);
        e = vpn % ENT;
        eh = (mtag[kmap(lk_kind)][e] == vpn);
        check(lk_hit == eh, rq, lk_hit, eh);
        if (eh) check(lk_paddr == {mppn[e][PW-1:0], lk_vaddr[11:0]}, rq,
                      lk_paddr, {mppn[e][PW-1:0], lk_vaddr[11:0]});
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic look(input logic [VW-1:0] v, input logic [11:0] o, input logic [1:0] k);
        lk_vaddr = {v, o};
        lk_kind = k;
        #1;
    endtask

    task automatic expect_hit(input bit e, input string rq);
        check(lk_hit == e, rq, lk_hit, e);
    endtask

    task automatic refill(input logic [1:0] k, input logic [VW-1:0] v, input logic [PW-1:0] p);
        rf_valid = 1'b1; rf_kind = k; rf_vpn = v; rf_ppn = p;
    endtask

    task automatic idle();
        rf_valid = 1'b0; flush = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); step("R8"); step("R8");
        rst_n = 1'b1;
        // R8: empty after reset
        look(20'h12345, 12'h0, 2'd1); expect_hit(0, "R8"); step("R8");

        // R10: refill invisible in its own cycle
        refill(2'd1, 20'h12345, 22'h0AAAA);
        look(20'h12345, 12'h0, 2'd1); expect_hit(0, "R10"); step("R10");
        idle();
        // R2/R3: load hits with joined address, fetch and store miss
        look(20'h12345, 12'hABC, 2'd1); expect_hit(1, "R2");
        check(lk_paddr == {22'h0AAAA, 12'hABC}, "R3", lk_paddr, {22'h0AAAA, 12'hABC});
        step("R3");
        look(20'h12345, 12'h0, 2'd0); expect_hit(0, "R2"); step("R2");
        look(20'h12345, 12'h0, 2'd2); expect_hit(0, "R2"); step("R2");
        look(20'h12345, 12'h001, 2'd3); expect_hit(1, "R2"); step("R2");

        // R4/R6: store refill keeps load tag, replaces shared number
        refill(2'd2, 20'h12345, 22'h0BBBB); step("R4"); idle();
        look(20'h12345, 12'h010, 2'd1); expect_hit(1, "R4");
        check(lk_paddr == {22'h0BBBB, 12'h010}, "R6", lk_paddr, {22'h0BBBB, 12'h010});
        step("R6");

        // R5: fetch refill of another page at same index scrubs the others
        refill(2'd0, 20'h12355, 22'h0CCCC); step("R5"); idle();
        look(20'h12345, 12'h0, 2'd1); expect_hit(0, "R5"); step("R5");
        look(20'h12345, 12'h0, 2'd2); expect_hit(0, "R5"); step("R5");
        look(20'h12355, 12'h0, 2'd0); expect_hit(1, "R5"); step("R5");

        // R1: two indices coexist
        refill(2'd1, 20'h00003, 22'h00033); step("R1");
        refill(2'd1, 20'h00004, 22'h00044); step("R1"); idle();
        look(20'h00003, 12'h0, 2'd1); expect_hit(1, "R1"); step("R1");
        look(20'h00004, 12'h0, 2'd1); expect_hit(1, "R1"); step("R1");
        look(20'h00013, 12'h0, 2'd1); expect_hit(0, "R1"); step("R1");

        // R7: flush wins over same-cycle refill
        flush = 1'b1; refill(2'd1, 20'h00005, 22'h00055); step("R7"); idle();
        look(20'h00005, 12'h0, 2'd1); expect_hit(0, "R7"); step("R7");
        look(20'h00003, 12'h0, 2'd1); expect_hit(0, "R7"); step("R7");

        // R9: all-ones page does not alias the invalid marker
        for (int k = 0; k < 3; k++) begin
            look(20'hFFFFF, 12'h0, 2'(k)); expect_hit(0, "R9"); step("R9");
        end
        refill(2'd2, 20'hFFFFF, 22'h3FFFF); step("R9"); idle();
        look(20'hFFFFF, 12'h0, 2'd2); expect_hit(1, "R9"); step("R9");

        // Mixed traffic against the model every clock.
        for (int n = 0; n < 600; n++) begin
            logic [VW-1:0] v;
            v = {$urandom_range(0, 3) == 0 ? 15'h7FFF : 15'h0, 5'($urandom)};
            rf_valid = ($urandom_range(0, 2) == 0);
            rf_kind = 2'($urandom);
            rf_vpn = {15'h0, 5'($urandom)};
            rf_ppn = 22'($urandom);
            flush = ($urandom_range(0, 40) == 0);
            rst_n = ($urandom_range(0, 80) != 0);
            lk_vaddr = {v, 12'($urandom)};
            lk_kind = 2'($urandom);
            step("R2");
        end
        rst_n = 1'b1; idle(); step("R8");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule